// File: doc/BRIEF.md
# Pending Exception Trap Controller

This block gathers asynchronous exception conditions from a processor core and turns them into one trap request at a time. Three kinds of condition are handled. The first is an overflow flagged by an add or subtract step inside an extended arithmetic instruction, such as a multiply/accumulate or an FFT step. The second is a parity error reported for one of several memory regions. The third is an interrupt, raised by an external line, the timer or an I/O control source. Overflow and parity events are short pulses, so each is caught in its own pending latch. The latch holds the event while the trap is blocked, either by the interrupt-lock flag or by a higher-priority exception that is in progress.

When no blocking condition is present, the controller picks the highest-priority pending condition. It raises a registered trap request with a 2-bit cause code and holds both until the core acknowledges. The acknowledge retires only the selected condition. Taking an interrupt trap sets the lock flag L and the interrupt-mode flag I. A return from the handler restores both flags through a status load input. The controller leaves instruction decode, vector fetch and parity generation to other blocks.

Top module: `exc_trap_ctrl`

## Requirements
- R1: After reset `trap_req` is 0, `trap_cause` is 0, `flag_l` is 1, `flag_i` is 0, and no condition is pending.
- R2: An `ovf_pulse` sampled while `ovf_dis` is 0 sets the pending overflow. A pulse sampled while `ovf_dis` is 1 has no effect and produces no trap.
- R3: In any cycle where `ovf_dis` is 1, the pending overflow is cleared, so a blocked overflow never traps once it has been disabled.
- R4: Several overflow pulses that arrive before the overflow trap is taken produce exactly one trap.
- R5: Bit k of `par_err` reports memory region k. Bit k of `par_dis` disables that region when it is 1. A parity error sets the pending parity latch only for a region whose disable bit is 0.
- R6: The pending parity condition is cleared only by acknowledging its trap. Setting `par_dis` bits after it is latched does not clear it.
- R7: No new request is raised in a cycle where `flag_l` or `hi_pri_busy` is 1. Pending conditions are kept while blocked. A request appears at the first clock edge at which the block samples both as 0.
- R8: Priority is parity, then overflow, then interrupt. `trap_cause` reads 01 for parity, 10 for overflow, 11 for interrupt, and 00 whenever `trap_req` is 0.
- R9: Once raised, `trap_req` and `trap_cause` stay unchanged until a clock edge with `trap_ack` = 1, even if blocking returns. The acknowledge drops the request at that edge and clears only the selected condition's latch.
- R10: Any bit of `irq_src` (0 external, 1 timer, 2 I/O control) requests an interrupt trap while L is 0. Acknowledging an interrupt trap sets both `flag_l` and `flag_i` to 1.
- R11: `sr_load` loads `flag_l` from `sr_l` and `flag_i` from `sr_i`. An interrupt acknowledge in the same cycle takes precedence and sets both flags.
- R12: An overflow pulse in the same cycle as the acknowledge of an overflow trap is not lost. It leaves the overflow pending, and it traps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released upstream |
| ovf_pulse | input | 1 | Extended-arithmetic overflow event |
| ovf_dis | input | 1 | Overflow exception disable bit (1 = disabled) |
| par_err | input | NAREA | Per-region parity error events |
| par_dis | input | NAREA | Per-region parity exception disable bits (1 = disabled) |
| irq_src | input | NIRQ | Interrupt sources: external, timer, I/O control |
| hi_pri_busy | input | 1 | A higher-priority exception is active |
| trap_ack | input | 1 | Core acknowledges the current trap request |
| sr_load | input | 1 | Return restores the status flags |
| sr_l | input | 1 | Saved lock flag value |
| sr_i | input | 1 | Saved interrupt-mode flag value |
| trap_req | output | 1 | Trap request, held until acknowledged |
| trap_cause | output | 2 | Encoded cause of the current request |
| flag_l | output | 1 | Interrupt-lock flag L |
| flag_i | output | 1 | Interrupt-mode flag I |

## Verification
The properties assume that `trap_ack` is asserted only while `trap_req` is high. They also assume that `irq_src` is a level held by its source, not a pulse. The stimulus raises the acknowledge only in cycles where a request is visible. It holds the interrupt sources steady across each arbitration, and it drops them only once L is set again. It never issues `sr_load` together with an acknowledge, except in the one case that R11 defines.

// File: rtl/exc_trap_pkg.sv
package exc_trap_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_PAR  = 2'b01,
    CAUSE_OVF  = 2'b10,
    CAUSE_IRQ  = 2'b11
  } trap_cause_e;

  localparam int unsigned CAUSE_W = 2;

endpackage

// File: rtl/exc_ovf_latch.sv
module exc_ovf_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic dis_i,
  input  logic clr_i,
  output logic pend_o
);

  logic pend_q;
  logic pend_d;

  // disable dominates; a new event outranks the acknowledge clear
  always_comb begin
    pend_d = pend_q;
    if (dis_i)      pend_d = 1'b0;
    else if (set_i) pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/exc_par_latch.sv
module exc_par_latch #(
  parameter int unsigned NAREA = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NAREA-1:0] err_i,
  input  logic [NAREA-1:0] dis_i,
  input  logic             clr_i,
  output logic             pend_o
);

  logic [NAREA-1:0] area_hit;
  logic             any_hit;
  logic             pend_q;
  logic             pend_d;

  genvar a;
  generate
    for (a = 0; a < NAREA; a++) begin : g_area
      assign area_hit[a] = err_i[a] & ~dis_i[a];
    end
  endgenerate

  assign any_hit = |area_hit;

  // disable bits gate only new events, never the held condition
  always_comb begin
    pend_d = pend_q;
    if (any_hit)    pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/exc_trap_arb.sv
module exc_trap_arb
  import exc_trap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        par_pend_i,
  input  logic        ovf_pend_i,
  input  logic        irq_live_i,
  input  logic        blocked_i,
  input  logic        ack_i,
  output logic        req_o,
  output trap_cause_e cause_o,
  output logic        take_par_o,
  output logic        take_ovf_o,
  output logic        take_irq_o
);

  logic        req_q, req_d;
  trap_cause_e cause_q, cause_d;
  trap_cause_e pick;
  logic        take;

  always_comb begin
    if (par_pend_i)      pick = CAUSE_PAR;
    else if (ovf_pend_i) pick = CAUSE_OVF;
    else if (irq_live_i) pick = CAUSE_IRQ;
    else                 pick = CAUSE_NONE;
  end

  assign take = req_q & ack_i;

  always_comb begin
    req_d   = req_q;
    cause_d = cause_q;
    if (req_q) begin
      if (ack_i) begin
        req_d   = 1'b0;
        cause_d = CAUSE_NONE;
      end
    end else if (!blocked_i && pick != CAUSE_NONE) begin
      req_d   = 1'b1;
      cause_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      req_q   <= req_d;
      cause_q <= cause_d;
    end
  end

  assign req_o      = req_q;
  assign cause_o    = cause_q;
  assign take_par_o = take && (cause_q == CAUSE_PAR);
  assign take_ovf_o = take && (cause_q == CAUSE_OVF);
  assign take_irq_o = take && (cause_q == CAUSE_IRQ);

endmodule

// File: rtl/exc_stat_flags.sv
module exc_stat_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic take_irq_i,
  input  logic load_i,
  input  logic load_l_i,
  input  logic load_i_i,
  output logic flag_l_o,
  output logic flag_i_o
);

  logic l_q, l_d;
  logic i_q, i_d;
  logic upd;

  assign upd = take_irq_i | load_i;

  always_comb begin
    l_d = l_q;
    i_d = i_q;
    if (take_irq_i) begin
      l_d = 1'b1;
      i_d = 1'b1;
    end else if (load_i) begin
      l_d = load_l_i;
      i_d = load_i_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q <= 1'b1;
      i_q <= 1'b0;
    end else if (upd) begin
      l_q <= l_d;
      i_q <= i_d;
    end
  end

  assign flag_l_o = l_q;
  assign flag_i_o = i_q;

endmodule

// File: rtl/exc_trap_ctrl.sv
module exc_trap_ctrl
  import exc_trap_pkg::*;
#(
  parameter int unsigned NAREA = 4,
  parameter int unsigned NIRQ  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ovf_pulse,
  input  logic               ovf_dis,
  input  logic [NAREA-1:0]   par_err,
  input  logic [NAREA-1:0]   par_dis,
  input  logic [NIRQ-1:0]    irq_src,
  input  logic               hi_pri_busy,
  input  logic               trap_ack,
  input  logic               sr_load,
  input  logic               sr_l,
  input  logic               sr_i,
  output logic               trap_req,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic               flag_l,
  output logic               flag_i
);

  logic        ovf_pend;
  logic        par_pend;
  logic        irq_live;
  logic        blocked;
  logic        take_par;
  logic        take_ovf;
  logic        take_irq;
  trap_cause_e cause;

  assign irq_live = |irq_src;
  assign blocked  = flag_l | hi_pri_busy;

  exc_ovf_latch u_ovf (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ovf_pulse),
    .dis_i  (ovf_dis),
    .clr_i  (take_ovf),
    .pend_o (ovf_pend)
  );

  exc_par_latch #(.NAREA(NAREA)) u_par (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_i  (par_err),
    .dis_i  (par_dis),
    .clr_i  (take_par),
    .pend_o (par_pend)
  );

  exc_trap_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_pend_i (par_pend),
    .ovf_pend_i (ovf_pend),
    .irq_live_i (irq_live),
    .blocked_i  (blocked),
    .ack_i      (trap_ack),
    .req_o      (trap_req),
    .cause_o    (cause),
    .take_par_o (take_par),
    .take_ovf_o (take_ovf),
    .take_irq_o (take_irq)
  );

  exc_stat_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_irq_i (take_irq),
    .load_i     (sr_load),
    .load_l_i   (sr_l),
    .load_i_i   (sr_i),
    .flag_l_o   (flag_l),
    .flag_i_o   (flag_i)
  );

  assign trap_cause = cause;

endmodule

// File: rtl/exc_trap_ctrl_chk.sv
module exc_trap_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trap_req,
  input logic [1:0] trap_cause,
  input logic       trap_ack,
  input logic       flag_l,
  input logic       flag_i,
  input logic       hi_pri_busy,
  input logic       ovf_dis,
  input logic       ovf_pend,
  input logic       par_pend
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !trap_ack |=> trap_req && $stable(trap_cause));

  // R8
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req == (trap_cause != 2'b00));

  // R7
  unblocked_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> $past(!hi_pri_busy && !flag_l));

  // R3
  ovf_dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_dis |=> !ovf_pend);

  // R6
  par_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_pend && !(trap_req && trap_ack && trap_cause == 2'b01) |=> par_pend);

  // R10
  irq_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && trap_ack && trap_cause == 2'b11 |=> flag_l && flag_i);

  // R8
  par_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) && $past(par_pend) |-> trap_cause == 2'b01);

endmodule

bind exc_trap_ctrl exc_trap_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trap_req    (trap_req),
  .trap_cause  (trap_cause),
  .trap_ack    (trap_ack),
  .flag_l      (flag_l),
  .flag_i      (flag_i),
  .hi_pri_busy (hi_pri_busy),
  .ovf_dis     (ovf_dis),
  .ovf_pend    (ovf_pend),
  .par_pend    (par_pend)
);

// File: tb/exc_trap_ctrl_test.sv
`timescale 1ns/100ps
module exc_trap_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ovf_pulse = 1'b0, ovf_dis = 1'b0;
  logic [3:0] par_err = 4'h0, par_dis = 4'h0;
  logic [2:0] irq_src = 3'b000;
  logic       hi_pri_busy = 1'b0, trap_ack = 1'b0;
  logic       sr_load = 1'b0, sr_l = 1'b0, sr_i = 1'b0;
  logic       trap_req;
  logic [1:0] trap_cause;
  logic       flag_l, flag_i;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  exc_trap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ovf_pulse(ovf_pulse), .ovf_dis(ovf_dis),
    .par_err(par_err), .par_dis(par_dis), .irq_src(irq_src),
    .hi_pri_busy(hi_pri_busy), .trap_ack(trap_ack), .sr_load(sr_load),
    .sr_l(sr_l), .sr_i(sr_i), .trap_req(trap_req), .trap_cause(trap_cause),
    .flag_l(flag_l), .flag_i(flag_i)
  );

  // behavioural reference: pending events, the held request, the flags
  bit m_ovf, m_par, m_req, m_l, m_i;
  int m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ovf = 0; m_par = 0; m_req = 0; m_cause = 0; m_l = 1; m_i = 0;
    end else begin
      bit taken, n_ovf, n_par, n_req, n_l, n_i;
      int n_cause;
      taken = m_req && trap_ack;
      n_req = m_req; n_cause = m_cause;
      if (m_req) begin
        if (trap_ack) begin n_req = 0; n_cause = 0; end
      end else if (!hi_pri_busy && !m_l) begin
        if (m_par) begin n_req = 1; n_cause = 1; end
        else if (m_ovf) begin n_req = 1; n_cause = 2; end
        else if (irq_src != 0) begin n_req = 1; n_cause = 3; end
      end
      n_ovf = m_ovf;
      if (ovf_dis) n_ovf = 0;
      else if (ovf_pulse) n_ovf = 1;
      else if (taken && m_cause == 2) n_ovf = 0;
      n_par = m_par;
      if ((par_err & ~par_dis) != 0) n_par = 1;
      else if (taken && m_cause == 1) n_par = 0;
      n_l = m_l; n_i = m_i;
      if (taken && m_cause == 3) begin n_l = 1; n_i = 1; end
      else if (sr_load) begin n_l = sr_l; n_i = sr_i; end
      m_ovf = n_ovf; m_par = n_par; m_req = n_req; m_cause = n_cause;
      m_l = n_l; m_i = n_i;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (trap_req !== m_req) begin
        errors++;
        $display("FAIL R9 model trap_req actual=%0b expected=%0b", trap_req, m_req);
      end
      checks++;
      if (trap_cause !== 2'(m_cause)) begin
        errors++;
        $display("FAIL R8 model trap_cause actual=%0d expected=%0d", trap_cause, m_cause);
      end
      checks++;
      if ({flag_l, flag_i} !== {m_l, m_i}) begin
        errors++;
        $display("FAIL R10 model flags actual=%b expected=%b", {flag_l, flag_i}, {m_l, m_i});
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic req, input logic [1:0] cause,
                            input logic l, input logic i);
    checks++;
    if ({trap_req, trap_cause, flag_l, flag_i} !== {req, cause, l, i}) begin
      errors++;
      $display("FAIL %s req/cause/L/I actual=%b expected=%b", tag,
               {trap_req, trap_cause, flag_l, flag_i}, {req, cause, l, i});
    end
  endtask

  task automatic ack_once();
    trap_ack = 1'b1;
    step();
    trap_ack = 1'b0;
  endtask

  task automatic restore_flags();
    sr_load = 1'b1; sr_l = 1'b0; sr_i = 1'b0;
    step();
    sr_load = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    expect_out("R1 reset", 1'b0, 2'b00, 1'b1, 1'b0);

    // R4 / R7: two overflows while L=1 stay pending as one
    ovf_pulse = 1'b1; step(); step(); ovf_pulse = 1'b0;
    step();
    expect_out("R7 blocked by L", 1'b0, 2'b00, 1'b1, 1'b0);
    restore_flags();
    expect_out("R11 restore", 1'b0, 2'b00, 1'b0, 1'b0);
    step();
    expect_out("R2 overflow trap", 1'b1, 2'b10, 1'b0, 1'b0);
    ack_once();
    expect_out("R9 ack drops", 1'b0, 2'b00, 1'b0, 1'b0);
    step(); step();
    expect_out("R4 single trap", 1'b0, 2'b00, 1'b0, 1'b0);

    // R2: disabled overflow ignored
    ovf_dis = 1'b1; ovf_pulse = 1'b1; step(); ovf_pulse = 1'b0;
    step(); step();
    expect_out("R2 disabled", 1'b0, 2'b00, 1'b0, 1'b0);
    ovf_dis = 1'b0;

    // R3: disable clears a blocked pending overflow
    hi_pri_busy = 1'b1; ovf_pulse = 1'b1; step(); ovf_pulse = 1'b0;
    ovf_dis = 1'b1; step(); ovf_dis = 1'b0; hi_pri_busy = 1'b0;
    step(); step();
    expect_out("R3 disable clears", 1'b0, 2'b00, 1'b0, 1'b0);

    // R5: per-region enables
    par_dis = 4'b1011; par_err = 4'b1011; step(); par_err = 4'h0;
    step(); step();
    expect_out("R5 masked regions", 1'b0, 2'b00, 1'b0, 1'b0);
    par_err = 4'b0100; step(); par_err = 4'h0;
    step();
    expect_out("R5 enabled region", 1'b1, 2'b01, 1'b0, 1'b0);
    ack_once();
    expect_out("R5 ack", 1'b0, 2'b00, 1'b0, 1'b0);

    // R6: later disable does not clear parity
    hi_pri_busy = 1'b1; par_err = 4'b0100; step(); par_err = 4'h0;
    par_dis = 4'hF; step(); step();
    hi_pri_busy = 1'b0; step();
    expect_out("R6 parity kept", 1'b1, 2'b01, 1'b0, 1'b0);
    ack_once();
    expect_out("R6 cleared by ack", 1'b0, 2'b00, 1'b0, 1'b0);
    par_dis = 4'h0;

    // R8 / R9 / R10: all three pending at once
    hi_pri_busy = 1'b1; par_err = 4'b0001; ovf_pulse = 1'b1; irq_src = 3'b001;
    step(); par_err = 4'h0; ovf_pulse = 1'b0; hi_pri_busy = 1'b0;
    step();
    expect_out("R8 parity first", 1'b1, 2'b01, 1'b0, 1'b0);
    ack_once();
    expect_out("R9 ack only parity", 1'b0, 2'b00, 1'b0, 1'b0);
    step();
    expect_out("R8 overflow second", 1'b1, 2'b10, 1'b0, 1'b0);
    ack_once();
    step();
    expect_out("R8 interrupt third", 1'b1, 2'b11, 1'b0, 1'b0);
    ack_once();
    expect_out("R10 flags set", 1'b0, 2'b00, 1'b1, 1'b1);
    step();
    expect_out("R10 locked", 1'b0, 2'b00, 1'b1, 1'b1);
    irq_src = 3'b000;

    // R9 hold across blocking, R12 pulse on ack
    restore_flags();
    expect_out("R11 restore both", 1'b0, 2'b00, 1'b0, 1'b0);
    ovf_pulse = 1'b1; step(); ovf_pulse = 1'b0; step();
    expect_out("R9 overflow raised", 1'b1, 2'b10, 1'b0, 1'b0);
    hi_pri_busy = 1'b1; step(); step();
    expect_out("R9 held while busy", 1'b1, 2'b10, 1'b0, 1'b0);
    hi_pri_busy = 1'b0;
    trap_ack = 1'b1; ovf_pulse = 1'b1; step(); trap_ack = 1'b0; ovf_pulse = 1'b0;
    expect_out("R12 ack cycle", 1'b0, 2'b00, 1'b0, 1'b0);
    step();
    expect_out("R12 re-trap", 1'b1, 2'b10, 1'b0, 1'b0);
    ack_once(); step();
    expect_out("R12 done", 1'b0, 2'b00, 1'b0, 1'b0);

    // R10 timer source, R11 ack beats load
    irq_src = 3'b010; step();
    expect_out("R10 timer", 1'b1, 2'b11, 1'b0, 1'b0);
    sr_load = 1'b1; sr_l = 1'b0; sr_i = 1'b0; trap_ack = 1'b1;
    step(); sr_load = 1'b0; trap_ack = 1'b0; irq_src = 3'b000;
    expect_out("R11 ack over load", 1'b0, 2'b00, 1'b1, 1'b1);

    // R10 I/O control source
    restore_flags();
    irq_src = 3'b100; step();
    expect_out("R10 io source", 1'b1, 2'b11, 1'b0, 1'b0);
    ack_once(); irq_src = 3'b000;
    expect_out("R10 io flags", 1'b0, 2'b00, 1'b1, 1'b1);
    step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule